// File: doc/BRIEF.md
# Synchronous RAM FIFO with Shift-Register Addressing

This block is a single-clock first-in first-out buffer. Its storage is a 64-entry by 36-bit synchronous RAM. The write address and the read address are not binary counters. Each one is a 6-bit linear feedback shift register that steps through a fixed pseudo-random order. Both addresses follow the same order, so words still come out in the order they went in. A shift register needs one XOR gate per feedback tap, where a counter needs a carry chain. This makes the address logic cheaper.

A plain maximal-length register of this width has only 63 states. One extra term in the feedback inserts the all-zero state into the cycle, so every one of the 64 RAM entries is used. Each address carries a lap bit that toggles when the address returns to zero. The full and empty flags come from equality tests on the addresses and the lap bits, with no subtraction. A write is refused when the buffer is full, and a read is refused when it is empty. Read data appears one clock after an accepted read, as with a registered RAM output.

Top module: `lfsr_ram_fifo`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0 and `rdData` is 0.
- R2: Every 36-bit word that is accepted is returned exactly once, in the order it was written.
- R3: After a read is accepted at a clock edge, `rdData` shows the word from that edge onward. When no read is accepted at an edge, `rdData` keeps its previous value.
- R4: After 64 accepted writes with no reads, `full` is 1. All 64 entries hold data, and `full` and `empty` are never 1 at the same time.
- R5: A write while `full` is 1 (and no read in the same cycle) has no effect. The flags, the stored words and the later read sequence are unchanged.
- R6: A read while `empty` is 1 (and no write in the same cycle) has no effect. `empty` stays 1 and `rdData` keeps its value.
- R7: A write and a read in the same cycle, with the buffer neither full nor empty, are both accepted. The fill level and both flags are unchanged.
- R8: A write and a read in the same cycle while full: the read is accepted and the write is dropped, so `full` goes to 0.
- R9: A write and a read in the same cycle while empty: the write is accepted and the read is dropped, so `empty` goes to 0 and `rdData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Registered read word |
| full | output | 1 | No free entry |
| empty | output | 1 | No stored entry |

## Verification
A write and a read can arrive in the same cycle. How this resolves depends on the fill level: both are taken in the middle of the range, only the read is taken when full, and only the write is taken when empty. The bench drives both requests together at exactly these three fill levels, and again during a long random phase. A reference queue in the bench decides, from its own size before each edge, which requests are accepted. Each cycle it compares both flags with that queue and compares `rdData` with either the word it popped or the word held from the previous read.

// File: rtl/lfsr_fifo_pkg.sv
package lfsr_fifo_pkg;
  typedef struct packed {
    logic wrGo;
    logic rdGo;
  } fifoStrobe_t;

  localparam int DEF_DATA_W = 36;
  localparam int DEF_PTR_W  = 6;
endpackage

// File: rtl/lfsr_fifo_ptr.sv
module lfsr_fifo_ptr #(
  parameter int W = 6,
  parameter logic [W-1:0] TAPS = 6'b110000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] ptr,
  output logic         lap
);
  logic         feedback;
  logic [W-1:0] nextPtr;

  // Maximal-length feedback. The extra zero-detect term splices the all-zero
  // state into the cycle, so the register visits all 2**W addresses.
  always_comb begin
    feedback = (^(ptr & TAPS)) ^ (ptr[W-2:0] == '0);
    nextPtr  = {ptr[W-2:0], feedback};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      lap <= 1'b0;
    end else if (step) begin
      ptr <= nextPtr;
      if (nextPtr == '0) lap <= ~lap;
    end
  end
endmodule

// File: rtl/lfsr_fifo_ctrl.sv
module lfsr_fifo_ctrl
  import lfsr_fifo_pkg::*;
#(
  parameter int PTR_W = DEF_PTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             rdEn,
  output fifoStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             full,
  output logic             empty
);
  logic wrLap, rdLap, samePtr;

  lfsr_fifo_ptr #(.W(PTR_W)) u_wrPtr (
    .clk(clk), .rst(rst), .step(strobe.wrGo), .ptr(wrPtr), .lap(wrLap)
  );
  lfsr_fifo_ptr #(.W(PTR_W)) u_rdPtr (
    .clk(clk), .rst(rst), .step(strobe.rdGo), .ptr(rdPtr), .lap(rdLap)
  );

  always_comb begin
    samePtr     = (wrPtr == rdPtr);
    empty       = samePtr && (wrLap == rdLap);
    full        = samePtr && (wrLap != rdLap);
    strobe.wrGo = wrEn && !full;
    strobe.rdGo = rdEn && !empty;
  end
endmodule

// File: rtl/lfsr_fifo_mem.sv
module lfsr_fifo_mem
  import lfsr_fifo_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int PTR_W  = DEF_PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrGo) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.rdGo) rdData <= store[rdPtr];
  end
endmodule

// File: rtl/lfsr_ram_fifo.sv
module lfsr_ram_fifo
  import lfsr_fifo_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int PTR_W  = DEF_PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty
);
  fifoStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  lfsr_fifo_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty)
  );

  lfsr_fifo_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .rst(rst), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/lfsr_fifo_chk.sv
module lfsr_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic              full,
  input logic              empty,
  input logic [DATA_W-1:0] rdData,
  input logic [PTR_W-1:0]  wrPtr,
  input logic [PTR_W-1:0]  rdPtr
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> empty && !full && rdData == '0); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(full && empty)); // R4
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    full && wrEn && !rdEn |=> full && $stable(wrPtr) && $stable(rdPtr)); // R5
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    empty && rdEn && !wrEn |=> empty && $stable(rdData) && $stable(rdPtr)); // R6
  AST_MID_BOTH_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !full && !empty && wrEn && rdEn |=> !full && !empty); // R7
  AST_FULL_BOTH_READS: assert property (@(posedge clk) disable iff (rst)
    full && wrEn && rdEn |=> !full && $stable(wrPtr)); // R8
  AST_EMPTY_BOTH_WRITES: assert property (@(posedge clk) disable iff (rst)
    empty && wrEn && rdEn |=> !empty && $stable(rdData) && $stable(rdPtr)); // R9
endmodule

bind lfsr_ram_fifo lfsr_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .full(full), .empty(empty),
  .rdData(rdData), .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/lfsr_ram_fifo_bench.sv
module lfsr_ram_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          full, empty;

  int            nCheck = 0, nFail = 0;
  logic [DW-1:0] modelQ[$];
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] lastRd = '0;
  logic          acceptR = 1'b0;
  logic          checking = 1'b0;
  logic          done = 1'b0;
  string         curTag = "R1";

  lfsr_ram_fifo u_lfsr_ram_fifo (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .full(full), .empty(empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: decides acceptance from the model level and queues expected reads.
  task automatic step(input logic we, input logic [DW-1:0] wd, input logic re,
                      input string tag);
    logic aw, ar;
    @(negedge clk);
    curTag = tag;
    aw = we && (modelQ.size() < DEPTH);
    ar = re && (modelQ.size() > 0);
    if (ar) begin
      expQ.push_back(modelQ[0]);
      void'(modelQ.pop_front());
    end
    if (aw) modelQ.push_back(wd);
    acceptR = ar;
    wrEn = we; wrData = wd; rdEn = re;
  endtask

  // Monitor: compares flags and read data just after each edge.
  always @(posedge clk) begin
    #1;
    if (checking && !rst) begin
      check(empty == (modelQ.size() == 0), curTag, {35'd0, empty},
            {35'd0, modelQ.size() == 0}, "empty");
      check(full == (modelQ.size() == DEPTH), curTag, {35'd0, full},
            {35'd0, modelQ.size() == DEPTH}, "full");
      if (acceptR) begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check(rdData == e, curTag, rdData, e, "read word (R2 R3)");
        lastRd = e;
      end else begin
        check(rdData == lastRd, curTag, rdData, lastRd, "held word (R3)");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++; nCheck++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check(empty == 1'b1, "R1", {35'd0, empty}, 36'd1, "empty after reset");
    check(full == 1'b0, "R1", {35'd0, full}, 36'd0, "full after reset");
    check(rdData == '0, "R1", rdData, '0, "rdData after reset");
    checking = 1'b1;
    // R6 read on empty
    step(1'b0, '0, 1'b1, "R6");
    step(1'b0, '0, 1'b1, "R6");
    // R9 both on empty
    step(1'b1, 36'h9_0000_0009, 1'b1, "R9");
    step(1'b0, '0, 1'b1, "R9");
    // R4 fill all 64 entries
    for (int i = 0; i < DEPTH; i++) step(1'b1, 36'hA_0000_0000 + DW'(i * 7 + 1), 1'b0, "R4");
    // R5 write on full ignored
    step(1'b1, 36'hB_AD00_0BAD, 1'b0, "R5");
    step(1'b1, 36'hB_AD00_0BAE, 1'b0, "R5");
    // R8 both on full
    step(1'b1, 36'h8_0000_0008, 1'b1, "R8");
    step(1'b1, 36'h8_0000_0018, 1'b0, "R8");
    // drain to mid level, then R7 both in the middle
    for (int i = 0; i < 30; i++) step(1'b0, '0, 1'b1, "R2");
    for (int i = 0; i < 40; i++) step(1'b1, 36'h7_0000_0000 + DW'(i), 1'b1, "R7");
    // drain fully, ordering checked word by word
    for (int i = 0; i < DEPTH + 4; i++) step(1'b0, '0, 1'b1, "R2");
    // random mix
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 1)), {4'h5, 32'($urandom)}, 1'($urandom_range(0, 1)), "R3");
    step(1'b0, '0, 1'b0, "R3");
    step(1'b0, '0, 1'b0, "R3");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end
endmodule